// File: doc/BRIEF.md
# Exclusive Access Reservation Monitor

This block holds one load-linked / store-conditional reservation for a single processor context. A load-exclusive strobe arms the reservation and records the full physical address. Invalidations from other agents arrive on a snoop port, and a snoop that hits the reserved cache block drops the reservation. A store-exclusive strobe asks for a verdict. One cycle later the block reports whether the store may be sent to memory. It reports nothing about data and performs no memory access.

Addresses are compared at cache-block granularity: two addresses count as equal when they agree on every bit set in the `blk_mask` input. A request flagged as a swap skips the check and is always granted. A diagnostic counter tracks how many store-exclusives in a row have failed, and it pulses a livelock warning each time that count reaches a multiple of `WARN_PERIOD`.

The reservation is a two-state machine. The states are `RS_EMPTY` (no reservation) and `RS_HELD` (reservation armed). There are three transitions. ARM (`RS_EMPTY` or `RS_HELD` to `RS_HELD`) happens on a load-exclusive with no clearing event in the same cycle. DROP (`RS_HELD` to `RS_EMPTY`) happens on clear-exclusive, a snoop hit or any store-exclusive. STAY covers every other cycle.

Top module: `excl_monitor`

## Requirements
- R1: A load-exclusive (`ldx_valid`=1) with no clearing event in the same cycle sets `resv_armed` to 1 and loads the full `ldx_addr` into `resv_addr`, both visible after the next rising edge.
- R2: Address equality means `(a & blk_mask) == (b & blk_mask)`. Bits outside the mask never affect a match.
- R3: A snoop clears `resv_armed` only when the reservation is held and the snoop address matches `resv_addr` under R2. Any other snoop leaves `resv_armed` and `resv_addr` unchanged.
- R4: A store-exclusive with `stx_swap`=1 is granted (`verdict_pass`=1) whatever the reservation state or address.
- R5: A non-swap store-exclusive fails (`verdict_pass`=0, meaning status 0 and do not issue to memory) when no reservation is held or the addresses do not match. A failure leaves `resv_armed` at 0.
- R6: A non-swap store-exclusive to the reserved block while the reservation is held is granted (`verdict_pass`=1, may issue). A grant also clears `resv_armed`.
- R7: `fail_count` increments by one on each failed store-exclusive and returns to 0 on each granted one, swap included.
- R8: `livelock_warn` is high for exactly the one cycle in which an increment makes `fail_count` a nonzero multiple of `WARN_PERIOD`.
- R9: `clrex` clears `resv_armed` unconditionally after the next edge.
- R10: If a snoop hits the reserved block in the same cycle as a non-swap store-exclusive, the store fails and the reservation is cleared.
- R11: A clearing event (clrex, snoop hit or store-exclusive) in the same cycle as a load-exclusive takes priority. The load-exclusive is discarded: `resv_armed` ends at 0 and `resv_addr` keeps its previous value.
- R12: Synchronous active-high `rst` sets `resv_armed`, `resv_addr`, `fail_count`, `verdict_valid` and `livelock_warn` to 0. `verdict_valid` is high for exactly the cycle after each `stx_valid` cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| blk_mask | input | ADDR_W | Cache-block mask; set bits take part in comparisons |
| ldx_valid | input | 1 | Load-exclusive strobe |
| ldx_addr | input | ADDR_W | Load-exclusive physical address |
| snoop_valid | input | 1 | Invalidating snoop strobe |
| snoop_addr | input | ADDR_W | Snoop address |
| clrex | input | 1 | Clear-exclusive strobe |
| stx_valid | input | 1 | Store-exclusive request strobe |
| stx_addr | input | ADDR_W | Store-exclusive physical address |
| stx_swap | input | 1 | Request is a swap; bypass the check |
| verdict_valid | output | 1 | Verdict present this cycle |
| verdict_pass | output | 1 | 1 = granted, may issue; 0 = failed, status 0 |
| resv_armed | output | 1 | Reservation held |
| resv_addr | output | ADDR_W | Recorded reservation address |
| fail_count | output | CNT_W | Consecutive store-exclusive failures |
| livelock_warn | output | 1 | One-cycle livelock warning pulse |

## Verification
The assertions assume the strobes are zero or one each cycle and that `blk_mask` does not change while a request is in flight. Under those conditions a verdict always corresponds to the request of the previous cycle. They also assume `WARN_PERIOD` is at least 2, so a warning pulse cannot repeat on back-to-back cycles. The stimulus changes the mask only between scenarios and raises each strobe for exactly one cycle, except in the back-to-back failure run. The bench sets `WARN_PERIOD` to 5 so that the warning boundary can be reached.

// File: rtl/excl_monitor_pkg.sv
package excl_monitor_pkg;

    typedef enum logic {
        RS_EMPTY = 1'b0,
        RS_HELD  = 1'b1
    } resv_state_e;

endpackage

// File: rtl/excl_monitor_resv.sv
module excl_monitor_resv
    import excl_monitor_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] blk_mask,
    input  logic              ldx_valid,
    input  logic [ADDR_W-1:0] ldx_addr,
    input  logic              snoop_valid,
    input  logic [ADDR_W-1:0] snoop_addr,
    input  logic              clrex,
    input  logic              stx_valid,
    output logic              armed,
    output logic [ADDR_W-1:0] held_addr,
    output logic              snoop_hit
);

    resv_state_e state_q, state_d;
    logic [ADDR_W-1:0] addr_q;
    logic drop_evt;
    logic arm_evt;

    always_comb begin
        snoop_hit = snoop_valid && (state_q == RS_HELD)
                    && ((snoop_addr & blk_mask) == (addr_q & blk_mask));
        drop_evt  = clrex || snoop_hit || stx_valid;
        arm_evt   = ldx_valid && !drop_evt;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            RS_EMPTY: begin
                if (arm_evt) state_d = RS_HELD;      // ARM
            end
            RS_HELD: begin
                if (drop_evt)     state_d = RS_EMPTY; // DROP
                else if (arm_evt) state_d = RS_HELD;  // ARM (re-target)
            end
            default: state_d = RS_EMPTY;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= RS_EMPTY;
        end else begin
            state_q <= state_d;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            addr_q <= '0;
        end else if (arm_evt) begin
            addr_q <= ldx_addr;
        end
    end

    always_comb begin
        armed     = (state_q == RS_HELD);
        held_addr = addr_q;
    end

    AST_ARM_RECORDS: assert property (@(posedge clk) disable iff (rst)
        (ldx_valid && !clrex && !stx_valid && !snoop_valid)
        |=> (armed && held_addr == $past(ldx_addr))); // R1

    AST_SNOOP_DROPS: assert property (@(posedge clk) disable iff (rst)
        snoop_hit |=> !armed); // R3

    AST_CLREX_DROPS: assert property (@(posedge clk) disable iff (rst)
        clrex |=> !armed); // R9

    AST_CLEAR_BEATS_LDX: assert property (@(posedge clk) disable iff (rst)
        (ldx_valid && (clrex || stx_valid))
        |=> (!armed && $stable(held_addr))); // R11

endmodule

// File: rtl/excl_monitor_judge.sv
module excl_monitor_judge #(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] blk_mask,
    input  logic              armed,
    input  logic [ADDR_W-1:0] held_addr,
    input  logic              snoop_hit,
    input  logic              stx_valid,
    input  logic [ADDR_W-1:0] stx_addr,
    input  logic              stx_swap,
    output logic              grant_now,
    output logic              fail_now,
    output logic              verdict_valid,
    output logic              verdict_pass
);

    logic addr_match;
    logic check_ok;
    logic valid_q, pass_q;

    always_comb begin
        addr_match = ((stx_addr & blk_mask) == (held_addr & blk_mask));
        check_ok   = armed && addr_match && !snoop_hit;
        grant_now  = stx_valid && (stx_swap || check_ok);
        fail_now   = stx_valid && !stx_swap && !check_ok;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            valid_q <= 1'b0;
            pass_q  <= 1'b0;
        end else begin
            valid_q <= stx_valid;
            pass_q  <= grant_now;
        end
    end

    always_comb begin
        verdict_valid = valid_q;
        verdict_pass  = pass_q;
    end

    AST_SWAP_GRANTED: assert property (@(posedge clk) disable iff (rst)
        (stx_valid && stx_swap) |=> (verdict_valid && verdict_pass)); // R4

    AST_UNARMED_FAILS: assert property (@(posedge clk) disable iff (rst)
        (stx_valid && !stx_swap && !armed) |=> (verdict_valid && !verdict_pass)); // R5

    AST_SNOOP_RACE_FAILS: assert property (@(posedge clk) disable iff (rst)
        (stx_valid && !stx_swap && snoop_hit) |=> !verdict_pass); // R10

    AST_VERDICT_FOLLOWS_REQ: assert property (@(posedge clk) disable iff (rst)
        verdict_valid |-> $past(stx_valid)); // R12

    AST_PASS_NEEDS_VALID: assert property (@(posedge clk) disable iff (rst)
        verdict_pass |-> verdict_valid); // R12

endmodule

// File: rtl/excl_monitor_failctr.sv
module excl_monitor_failctr #(
    parameter int CNT_W       = 32,
    parameter int WARN_PERIOD = 100000
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             grant_now,
    input  logic             fail_now,
    output logic [CNT_W-1:0] fail_count,
    output logic             livelock_warn
);

    localparam int PH_W = (WARN_PERIOD > 1) ? $clog2(WARN_PERIOD) : 1;
    localparam logic [PH_W-1:0] PH_LAST = PH_W'(WARN_PERIOD - 1);

    logic [CNT_W-1:0] count_q;
    logic [PH_W-1:0]  phase_q;
    logic             warn_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            count_q <= '0;
            phase_q <= '0;
            warn_q  <= 1'b0;
        end else begin
            warn_q <= 1'b0;
            if (grant_now) begin
                count_q <= '0;
                phase_q <= '0;
            end else if (fail_now) begin
                count_q <= count_q + 1'b1;
                if (phase_q == PH_LAST) begin
                    phase_q <= '0;
                    warn_q  <= 1'b1;
                end else begin
                    phase_q <= phase_q + 1'b1;
                end
            end
        end
    end

    always_comb begin
        fail_count    = count_q;
        livelock_warn = warn_q;
    end

    AST_FAIL_INCREMENTS: assert property (@(posedge clk) disable iff (rst)
        fail_now |=> (fail_count == $past(fail_count) + 1'b1)); // R7

    AST_GRANT_ZEROES: assert property (@(posedge clk) disable iff (rst)
        grant_now |=> (fail_count == '0)); // R7

    AST_WARN_SINGLE: assert property (@(posedge clk) disable iff (rst)
        livelock_warn |=> !livelock_warn); // R8

    AST_WARN_AFTER_FAIL: assert property (@(posedge clk) disable iff (rst)
        livelock_warn |-> $past(fail_now)); // R8

endmodule

// File: rtl/excl_monitor.sv
module excl_monitor #(
    parameter int ADDR_W      = 32,
    parameter int CNT_W       = 32,
    parameter int WARN_PERIOD = 100000
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] blk_mask,
    input  logic              ldx_valid,
    input  logic [ADDR_W-1:0] ldx_addr,
    input  logic              snoop_valid,
    input  logic [ADDR_W-1:0] snoop_addr,
    input  logic              clrex,
    input  logic              stx_valid,
    input  logic [ADDR_W-1:0] stx_addr,
    input  logic              stx_swap,
    output logic              verdict_valid,
    output logic              verdict_pass,
    output logic              resv_armed,
    output logic [ADDR_W-1:0] resv_addr,
    output logic [CNT_W-1:0]  fail_count,
    output logic              livelock_warn
);

    logic snoop_hit;
    logic grant_now;
    logic fail_now;

    excl_monitor_resv #(.ADDR_W(ADDR_W)) u_resv (
        .clk         (clk),
        .rst         (rst),
        .blk_mask    (blk_mask),
        .ldx_valid   (ldx_valid),
        .ldx_addr    (ldx_addr),
        .snoop_valid (snoop_valid),
        .snoop_addr  (snoop_addr),
        .clrex       (clrex),
        .stx_valid   (stx_valid),
        .armed       (resv_armed),
        .held_addr   (resv_addr),
        .snoop_hit   (snoop_hit)
    );

    excl_monitor_judge #(.ADDR_W(ADDR_W)) u_judge (
        .clk           (clk),
        .rst           (rst),
        .blk_mask      (blk_mask),
        .armed         (resv_armed),
        .held_addr     (resv_addr),
        .snoop_hit     (snoop_hit),
        .stx_valid     (stx_valid),
        .stx_addr      (stx_addr),
        .stx_swap      (stx_swap),
        .grant_now     (grant_now),
        .fail_now      (fail_now),
        .verdict_valid (verdict_valid),
        .verdict_pass  (verdict_pass)
    );

    excl_monitor_failctr #(.CNT_W(CNT_W), .WARN_PERIOD(WARN_PERIOD)) u_ctr (
        .clk           (clk),
        .rst           (rst),
        .grant_now     (grant_now),
        .fail_now      (fail_now),
        .fail_count    (fail_count),
        .livelock_warn (livelock_warn)
    );

    AST_STX_DROPS_RESV: assert property (@(posedge clk) disable iff (rst)
        stx_valid |=> !resv_armed); // R5 R6

    AST_ONE_OUTCOME: assert property (@(posedge clk) disable iff (rst)
        $countones({grant_now, fail_now}) == (stx_valid ? 1 : 0)); // R12

endmodule

// File: tb/tb_excl_monitor.sv
`timescale 1ns/1ps
module tb_excl_monitor;

    localparam int AW = 32;
    localparam int CW = 32;
    localparam int WP = 5;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [AW-1:0] blk_mask = '1;
    logic          ldx_valid = 1'b0;
    logic [AW-1:0] ldx_addr = '0;
    logic          snoop_valid = 1'b0;
    logic [AW-1:0] snoop_addr = '0;
    logic          clrex = 1'b0;
    logic          stx_valid = 1'b0;
    logic [AW-1:0] stx_addr = '0;
    logic          stx_swap = 1'b0;
    logic          verdict_valid, verdict_pass, resv_armed, livelock_warn;
    logic [AW-1:0] resv_addr;
    logic [CW-1:0] fail_count;

    int n_checks = 0;
    int n_fail   = 0;
    int cycles   = 0;

    always #2.5 clk = ~clk;

    excl_monitor #(.ADDR_W(AW), .CNT_W(CW), .WARN_PERIOD(WP)) dut (
        .clk(clk), .rst(rst), .blk_mask(blk_mask),
        .ldx_valid(ldx_valid), .ldx_addr(ldx_addr),
        .snoop_valid(snoop_valid), .snoop_addr(snoop_addr),
        .clrex(clrex), .stx_valid(stx_valid), .stx_addr(stx_addr),
        .stx_swap(stx_swap), .verdict_valid(verdict_valid),
        .verdict_pass(verdict_pass), .resv_armed(resv_armed),
        .resv_addr(resv_addr), .fail_count(fail_count),
        .livelock_warn(livelock_warn)
    );

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 20000) begin
            n_fail   = n_fail + 1;
            n_checks = n_checks + 1;
            $display("FAIL watchdog: act=hung exp=finished");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_checks = n_checks + 1;
        if (act !== exp) begin
            n_fail = n_fail + 1;
            $display("FAIL %s: act=%0h exp=%0h", req, act, exp);
        end
    endtask

    // Drive one cycle of strobes at a falling edge; return at the next falling edge.
    task automatic step(input logic l, input logic [AW-1:0] la,
                        input logic s, input logic [AW-1:0] sa,
                        input logic c,
                        input logic x, input logic [AW-1:0] xa, input logic sw);
        @(negedge clk);
        ldx_valid = l; ldx_addr = la;
        snoop_valid = s; snoop_addr = sa;
        clrex = c;
        stx_valid = x; stx_addr = xa; stx_swap = sw;
        @(negedge clk);
        ldx_valid = 0; snoop_valid = 0; clrex = 0; stx_valid = 0; stx_swap = 0;
    endtask

    task automatic do_ldx(input logic [AW-1:0] a);
        step(1, a, 0, '0, 0, 0, '0, 0);
    endtask

    task automatic do_stx(input logic [AW-1:0] a, input logic sw);
        step(0, '0, 0, '0, 0, 1, a, sw);
    endtask

    task automatic t_reset;
        chk("R12 armed", resv_armed, 0);
        chk("R12 addr", resv_addr, 0);
        chk("R12 count", fail_count, 0);
        chk("R12 valid", verdict_valid, 0);
        chk("R12 warn", livelock_warn, 0);
    endtask

    task automatic t_arm_and_pass;
        blk_mask = 32'hFFFF_FFC0;
        do_ldx(32'h1000);
        chk("R1 armed", resv_armed, 1);
        chk("R1 addr", resv_addr, 32'h1000);
        do_stx(32'h1020, 0);
        chk("R6 valid", verdict_valid, 1);
        chk("R6 pass (R2 same block)", verdict_pass, 1);
        chk("R6 cleared", resv_armed, 0);
        chk("R7 count after grant", fail_count, 0);
        @(negedge clk);
        chk("R12 valid one cycle", verdict_valid, 0);
    endtask

    task automatic t_fail_cases;
        do_ldx(32'h1000);
        do_stx(32'h2000, 0);
        chk("R5 mismatch fails", verdict_pass, 0);
        chk("R5 mismatch valid", verdict_valid, 1);
        chk("R5 cleared", resv_armed, 0);
        chk("R7 count 1", fail_count, 1);
        do_stx(32'h1000, 0);
        chk("R5 unarmed fails", verdict_pass, 0);
        chk("R7 count 2", fail_count, 2);
    endtask

    task automatic t_swap;
        do_stx(32'h9999_0000, 1);
        chk("R4 swap granted", verdict_pass, 1);
        chk("R7 swap zeroes count", fail_count, 0);
    endtask

    task automatic t_snoop;
        do_ldx(32'h3000);
        step(0, '0, 1, 32'h4000, 0, 0, '0, 0);
        chk("R3 miss keeps armed", resv_armed, 1);
        chk("R3 miss keeps addr", resv_addr, 32'h3000);
        step(0, '0, 1, 32'h3010, 0, 0, '0, 0);
        chk("R3 hit clears", resv_armed, 0);
        step(0, '0, 1, 32'h3000, 0, 0, '0, 0);
        chk("R3 snoop on empty", resv_armed, 0);
        chk("R3 addr kept", resv_addr, 32'h3000);
    endtask

    task automatic t_mask;
        blk_mask = 32'hFFFF_F000;
        do_ldx(32'h5000);
        do_stx(32'h5ABC, 0);
        chk("R2 wide mask match", verdict_pass, 1);
        blk_mask = 32'hFFFF_FFC0;
        do_ldx(32'h5000);
        do_stx(32'h5ABC, 0);
        chk("R2 narrow mask mismatch", verdict_pass, 0);
    endtask

    task automatic t_clrex;
        do_ldx(32'h8000);
        step(0, '0, 0, '0, 1, 0, '0, 0);
        chk("R9 clrex clears", resv_armed, 0);
        do_stx(32'h8000, 0);
        chk("R9 store after clrex fails", verdict_pass, 0);
    endtask

    task automatic t_race;
        do_ldx(32'h6000);
        step(0, '0, 1, 32'h6008, 0, 1, 32'h6000, 0);
        chk("R10 race fails", verdict_pass, 0);
        chk("R10 race valid", verdict_valid, 1);
        chk("R10 race cleared", resv_armed, 0);
    endtask

    task automatic t_ldx_priority;
        do_ldx(32'h7000);
        step(1, 32'h7400, 0, '0, 1, 0, '0, 0);
        chk("R11 clrex beats ldx", resv_armed, 0);
        chk("R11 addr unchanged", resv_addr, 32'h7000);
        step(1, 32'h7800, 0, '0, 0, 1, 32'h7000, 1);
        chk("R11 stx beats ldx", resv_armed, 0);
        chk("R11 addr unchanged 2", resv_addr, 32'h7000);
    endtask

    task automatic t_warn;
        do_stx(32'h0, 1);
        chk("R7 reset before run", fail_count, 0);
        @(negedge clk);
        stx_valid = 1; stx_addr = 32'hABC0; stx_swap = 0;
        for (int k = 1; k <= 11; k++) begin
            @(negedge clk);
            chk("R7 run count", fail_count, 64'(k));
            chk("R8 warn pulse", livelock_warn, (k % WP == 0) ? 1 : 0);
        end
        stx_valid = 0;
        @(negedge clk);
        chk("R8 warn low after run", livelock_warn, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        t_reset();
        t_arm_and_pass();
        t_fail_cases();
        t_swap();
        t_snoop();
        t_mask();
        t_clrex();
        t_race();
        t_ldx_priority();
        t_warn();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule